// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of the device side of a 1024-bit serial EEPROM. A host drives it through four wires: chip select, shift clock, data in, and a data output that has a separate output-enable because the pin would otherwise float. Each transaction is framed as a single 1 start bit, followed by a two-bit opcode, an address and, for the programming opcodes, a data word. The block runs on a fast system clock. It samples the serial wires through a synchronizer and acts on each rising edge of the shift clock.

A static strap sets the array shape. High gives 64 words of 16 bits. Low gives 128 bytes, with the same storage seen one byte at a time. Programming is allowed only while a persistent enable latch is set. A program cycle starts when chip select falls at the end of a complete programming frame. Its length is a parameterised number of system clocks, standing in for the self-timed cycle of a real part. If the host keeps chip select low long enough and then raises it, the data output reports busy (0) or ready (1).

Top module: `serial_eeprom_model`

## Requirements
- R1: After reset, every cell reads as all ones, programming is disabled, and `do_oe` is low.
- R2: Read is opcode 10. On the shift-clock edge that takes in the last address bit, the output drives a dummy 0 with `do_oe` high. Each of the next edges presents one data bit, MSB first.
- R3: With `org_x16` high, addresses are 6 bits and data is 16 bits. With it low, addresses are 7 bits and data is 8 bits. Byte address b lives in word b>>1, in the upper half when b[0]=0 and in the lower half when b[0]=1.
- R4: While programming is disabled, write, erase, write-all and erase-all frames change no cell.
- R5: Opcode 00 selects by the two address MSBs: 11 sets the enable latch and 00 clears it. The latch keeps its value across frames.
- R6: Write (opcode 01) replaces the addressed word or byte with the shifted-in data, with no erase needed first. Erase (opcode 11) sets it to all ones.
- R7: Opcode 00 with MSBs 01 writes the shifted-in pattern to every location. With MSBs 10 it sets every location to all ones.
- R8: A program cycle starts when chip select falls after a complete, enabled programming frame. It stays busy for PROG_CYCLES system clocks, and the status output reads 0 while busy and 1 after.
- R9: Status is driven only when chip select rises after having been low for at least CS_LOW_MIN system clocks following a program cycle. `do_oe` is low whenever chip select is low.
- R10: Zeros before the start bit are ignored. Dropping chip select before a frame is complete discards it.
- R11: While busy, data input is not decoded, so frames sent during a program cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| org_x16 | input | 1 | Organization strap: 1 = 16-bit words, 0 = bytes |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out / ready-busy status |
| do_oe | output | 1 | Output enable for `do_o` |

## Verification
On every cycle, the assertions check the following: the output enable is released when chip select is low; the dummy zero comes first in a read; the array is written only while the latch is enabled and never during a busy phase; and each busy phase lasts exactly the parameterised count. The byte-to-word mapping, the effect of enable and disable on later frames, the abort and leading-zero framing, the all-location operations, and the minimum chip-select low time before status appears can only be shown by the bench. It does this by sweeping every address in both organizations against an arithmetic model of the array.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } opc_e;

  typedef enum logic [1:0] {
    EXT_WDIS  = 2'b00,
    EXT_WRALL = 2'b01,
    EXT_ERALL = 2'b10,
    EXT_WEN   = 2'b11
  } ext_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_READ,
    ST_HOLD
  } st_e;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_WRITE,
    ACT_ERASE,
    ACT_WRALL,
    ACT_ERALL
  } act_e;

  // address length for the selected organization
  function automatic int unsigned addr_len(input logic x16, input int unsigned aw16);
    return x16 ? aw16 : aw16 + 1;
  endfunction

  // data length for the selected organization
  function automatic int unsigned data_len(input logic x16, input int unsigned word_w);
    return x16 ? word_w : word_w / 2;
  endfunction

  // byte address bit 0 = 0 selects the upper half of a word
  function automatic logic byte_is_upper(input logic b0);
    return !b0;
  endfunction

endpackage

// File: rtl/eeprom_in_sync.sv
module eeprom_in_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic cs_lvl,
  output logic cs_rise,
  output logic cs_fall,
  output logic sk_rise,
  output logic di_lvl
);

  logic [STAGES-1:0] cs_p;
  logic [STAGES-1:0] sk_p;
  logic [STAGES-2:0] di_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p <= '0;
      sk_p <= '0;
      di_p <= '0;
    end else begin
      cs_p <= {cs_p[STAGES-2:0], cs};
      sk_p <= {sk_p[STAGES-2:0], sk};
      di_p <= {di_p[STAGES-3:0], di};
    end
  end

  assign cs_lvl  = cs_p[STAGES-2];
  assign cs_rise = cs_p[STAGES-2] & ~cs_p[STAGES-1];
  assign cs_fall = ~cs_p[STAGES-2] & cs_p[STAGES-1];
  assign sk_rise = sk_p[STAGES-2] & ~sk_p[STAGES-1];
  assign di_lvl  = di_p[STAGES-2];

endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(PROG_CYCLES + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (start) begin
      remain <= CW'(PROG_CYCLES);
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign busy = (remain != '0);

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array
  import eeprom_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WORDS  = 64,
  localparam int AW16  = $clog2(WORDS),
  localparam int AW8   = AW16 + 1,
  localparam int HALF  = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x16,
  input  logic              act_go,
  input  act_e              act,
  input  logic [AW8-1:0]    act_addr,
  input  logic [WORD_W-1:0] act_data,
  input  logic [AW8-1:0]    rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] mem [WORDS];

  logic [AW16-1:0]   wsel;
  logic              w_upper;
  logic [WORD_W-1:0] all_pat;
  logic [AW16-1:0]   rsel;
  logic              r_upper;
  logic [WORD_W-1:0] rword;

  assign wsel    = x16 ? act_addr[AW16-1:0] : act_addr[AW8-1:1];
  assign w_upper = byte_is_upper(act_addr[0]);
  assign all_pat = x16 ? act_data : {2{act_data[HALF-1:0]}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (act_go) begin
      case (act)
        ACT_WRITE: begin
          if (x16)          mem[wsel] <= act_data;
          else if (w_upper) mem[wsel][WORD_W-1:HALF] <= act_data[HALF-1:0];
          else              mem[wsel][HALF-1:0] <= act_data[HALF-1:0];
        end
        ACT_ERASE: begin
          if (x16)          mem[wsel] <= '1;
          else if (w_upper) mem[wsel][WORD_W-1:HALF] <= '1;
          else              mem[wsel][HALF-1:0] <= '1;
        end
        ACT_WRALL: for (int i = 0; i < WORDS; i++) mem[i] <= all_pat;
        ACT_ERALL: for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        default: ;
      endcase
    end
  end

  assign rsel    = x16 ? rd_addr[AW16-1:0] : rd_addr[AW8-1:1];
  assign r_upper = byte_is_upper(rd_addr[0]);
  assign rword   = mem[rsel];
  assign rd_word = x16 ? rword
                 : {{HALF{1'b0}}, (r_upper ? rword[WORD_W-1:HALF] : rword[HALF-1:0])};

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int WORDS      = 64,
  parameter int CS_LOW_MIN = 25,
  localparam int AW16      = $clog2(WORDS),
  localparam int AW8       = AW16 + 1,
  localparam int HALF      = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x16,
  input  logic              cs_lvl,
  input  logic              cs_rise,
  input  logic              cs_fall,
  input  logic              sk_rise,
  input  logic              di_lvl,
  input  logic              busy,
  input  logic [WORD_W-1:0] rd_word,
  output logic              act_go,
  output act_e              act,
  output logic [AW8-1:0]    act_addr,
  output logic [WORD_W-1:0] act_data,
  output logic [AW8-1:0]    rd_addr,
  output logic              do_o,
  output logic              do_oe,
  output logic              en_state,
  output logic              rd_active,
  output logic              status_on
);

  localparam int CNT_W = $clog2(WORD_W + AW8 + 2) + 1;
  localparam int LW    = $clog2(CS_LOW_MIN + 1);

  st_e               st;
  logic [CNT_W-1:0]  cnt;
  logic [AW8:0]      cmd_sh;
  opc_e              op_q;
  logic [AW8-1:0]    addr_q;
  logic [WORD_W-1:0] data_sh;
  act_e              pend;
  logic [LW-1:0]     low_cnt;
  logic              armed;
  logic [WORD_W-1:0] out_sh;
  logic              do_q;

  logic [CNT_W-1:0]  cmd_len;
  logic [CNT_W-1:0]  dat_len;
  logic [AW8+1:0]    cmd_full;
  opc_e              dec_op;
  ext_e              dec_ext;
  logic [AW8-1:0]    dec_addr;
  logic [WORD_W-1:0] data_full;
  logic [WORD_W-1:0] rd_al;
  logic [CNT_W-1:0]  cnt_nx;

  assign cmd_len   = CNT_W'(addr_len(x16, AW16) + 2);
  assign dat_len   = CNT_W'(data_len(x16, WORD_W));
  assign cmd_full  = {cmd_sh, di_lvl};
  assign data_full = {data_sh[WORD_W-2:0], di_lvl};
  assign rd_al     = x16 ? rd_word : {rd_word[HALF-1:0], {HALF{1'b0}}};
  assign cnt_nx    = cnt + 1'b1;

  always_comb begin
    if (x16) begin
      dec_op   = opc_e'(cmd_full[AW16+1:AW16]);
      dec_ext  = ext_e'(cmd_full[AW16-1:AW16-2]);
      dec_addr = {1'b0, cmd_full[AW16-1:0]};
    end else begin
      dec_op   = opc_e'(cmd_full[AW8+1:AW8]);
      dec_ext  = ext_e'(cmd_full[AW8-1:AW8-2]);
      dec_addr = cmd_full[AW8-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      cmd_sh    <= '0;
      op_q      <= OP_READ;
      addr_q    <= '0;
      data_sh   <= '0;
      pend      <= ACT_NONE;
      en_state  <= 1'b0;
      low_cnt   <= '0;
      armed     <= 1'b0;
      status_on <= 1'b0;
      out_sh    <= '0;
      do_q      <= 1'b0;
      act_go    <= 1'b0;
      act       <= ACT_NONE;
      act_addr  <= '0;
      act_data  <= '0;
    end else begin
      act_go <= 1'b0;
      if (!cs_lvl) begin
        st        <= ST_IDLE;
        status_on <= 1'b0;
        pend      <= ACT_NONE;
        if (low_cnt != LW'(CS_LOW_MIN)) low_cnt <= low_cnt + 1'b1;
        if (cs_fall && st == ST_HOLD && pend != ACT_NONE) begin
          act_go   <= 1'b1;
          act      <= pend;
          act_addr <= addr_q;
          act_data <= data_sh;
          armed    <= 1'b1;
        end
      end else begin
        if (cs_rise) begin
          low_cnt <= '0;
          if (armed && low_cnt == LW'(CS_LOW_MIN)) status_on <= 1'b1;
        end
        if (sk_rise) begin
          case (st)
            ST_IDLE: begin
              if (di_lvl && !busy) begin
                st        <= ST_CMD;
                cnt       <= '0;
                cmd_sh    <= '0;
                status_on <= 1'b0;
                armed     <= 1'b0;
              end
            end
            ST_CMD: begin
              cmd_sh <= cmd_full[AW8:0];
              cnt    <= cnt_nx;
              if (cnt_nx == cmd_len) begin
                cnt    <= '0;
                addr_q <= dec_addr;
                op_q   <= dec_op;
                case (dec_op)
                  OP_READ: begin
                    st   <= ST_READ;
                    do_q <= 1'b0;
                  end
                  OP_WRITE: st <= ST_DATA;
                  OP_ERASE: begin
                    st   <= ST_HOLD;
                    pend <= en_state ? ACT_ERASE : ACT_NONE;
                  end
                  default: begin
                    case (dec_ext)
                      EXT_WEN: begin
                        en_state <= 1'b1;
                        st       <= ST_HOLD;
                      end
                      EXT_WDIS: begin
                        en_state <= 1'b0;
                        st       <= ST_HOLD;
                      end
                      EXT_ERALL: begin
                        st   <= ST_HOLD;
                        pend <= en_state ? ACT_ERALL : ACT_NONE;
                      end
                      default: st <= ST_DATA;
                    endcase
                  end
                endcase
              end
            end
            ST_DATA: begin
              data_sh <= data_full;
              cnt     <= cnt_nx;
              if (cnt_nx == dat_len) begin
                st <= ST_HOLD;
                if (!en_state)              pend <= ACT_NONE;
                else if (op_q == OP_WRITE)  pend <= ACT_WRITE;
                else                        pend <= ACT_WRALL;
              end
            end
            ST_READ: begin
              if (cnt == dat_len) begin
                st <= ST_HOLD;
              end else begin
                cnt <= cnt_nx;
                if (cnt == '0) begin
                  do_q   <= rd_al[WORD_W-1];
                  out_sh <= rd_al << 1;
                end else begin
                  do_q   <= out_sh[WORD_W-1];
                  out_sh <= out_sh << 1;
                end
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign rd_active = (st == ST_READ);
  assign rd_addr   = addr_q;
  assign do_oe     = rd_active | status_on;
  assign do_o      = rd_active ? do_q : ~busy;

endmodule

// File: rtl/serial_eeprom_model.sv
module serial_eeprom_model
  import eeprom_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int WORDS       = 64,
  parameter int PROG_CYCLES = 1000,
  parameter int CS_LOW_MIN  = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org_x16,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);

  localparam int AW16 = $clog2(WORDS);
  localparam int AW8  = AW16 + 1;

  logic              cs_lvl;
  logic              cs_rise;
  logic              cs_fall;
  logic              sk_rise;
  logic              di_lvl;
  logic              busy;
  logic              arr_we;
  act_e              act;
  logic [AW8-1:0]    act_addr;
  logic [WORD_W-1:0] act_data;
  logic [AW8-1:0]    rd_addr;
  logic [WORD_W-1:0] rd_word;
  logic              en_state;
  logic              rd_active;
  logic              status_on;

  eeprom_in_sync #(.STAGES(3)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .sk      (sk),
    .di      (di),
    .cs_lvl  (cs_lvl),
    .cs_rise (cs_rise),
    .cs_fall (cs_fall),
    .sk_rise (sk_rise),
    .di_lvl  (di_lvl)
  );

  eeprom_ctrl #(
    .WORD_W     (WORD_W),
    .WORDS      (WORDS),
    .CS_LOW_MIN (CS_LOW_MIN)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .x16       (org_x16),
    .cs_lvl    (cs_lvl),
    .cs_rise   (cs_rise),
    .cs_fall   (cs_fall),
    .sk_rise   (sk_rise),
    .di_lvl    (di_lvl),
    .busy      (busy),
    .rd_word   (rd_word),
    .act_go    (arr_we),
    .act       (act),
    .act_addr  (act_addr),
    .act_data  (act_data),
    .rd_addr   (rd_addr),
    .do_o      (do_o),
    .do_oe     (do_oe),
    .en_state  (en_state),
    .rd_active (rd_active),
    .status_on (status_on)
  );

  eeprom_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (arr_we),
    .busy  (busy)
  );

  eeprom_array #(.WORD_W(WORD_W), .WORDS(WORDS)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .x16      (org_x16),
    .act_go   (arr_we),
    .act      (act),
    .act_addr (act_addr),
    .act_data (act_data),
    .rd_addr  (rd_addr),
    .rd_word  (rd_word)
  );

endmodule

// File: rtl/eeprom_model_checker.sv
module eeprom_model_checker #(
  parameter int PROG_CYCLES = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic cs_lvl,
  input logic do_o,
  input logic do_oe,
  input logic rd_active,
  input logic arr_we,
  input logic en_state,
  input logic busy
);

  localparam int CW = $clog2(PROG_CYCLES + 2);

  logic [CW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  // R2: a read phase opens with the dummy zero
  p_dummy_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_active) |-> !do_o);

  // R4: the array only changes while the enable latch is set
  p_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> en_state);

  // R8: each busy phase lasts exactly the configured count
  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == CW'(PROG_CYCLES));

  // R8: status shows ready as soon as the busy phase ends
  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && do_oe && !rd_active) |-> do_o);

  // R9: the output is released while chip select is low
  p_oe_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lvl |=> !do_oe);

  // R11: no new program cycle starts during a busy phase
  p_no_commit_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !arr_we);

endmodule

bind serial_eeprom_model eeprom_model_checker #(.PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_lvl    (cs_lvl),
  .do_o      (do_o),
  .do_oe     (do_oe),
  .rd_active (rd_active),
  .arr_we    (arr_we),
  .en_state  (en_state),
  .busy      (busy)
);

// File: tb/sim_serial_eeprom_model.sv
`timescale 1ns/1ps
module sim_serial_eeprom_model;

  localparam int PROG  = 120;
  localparam int CSMIN = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic org_x16 = 1'b1;
  logic cs = 1'b0;
  logic sk = 1'b0;
  logic di = 1'b0;
  logic do_o;
  logic do_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] model [64];
  logic en_model = 1'b0;
  logic st_oe0, st_do0;
  int   st_cyc;

  always #5 clk = ~clk;

  serial_eeprom_model #(
    .WORD_W(16), .WORDS(64), .PROG_CYCLES(PROG), .CS_LOW_MIN(CSMIN)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .org_x16(org_x16), .cs(cs), .sk(sk), .di(di),
    .do_o(do_o), .do_oe(do_oe)
  );

  task automatic clk_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] p16(input int a);
    return 16'(a * 8003) ^ 16'h5A0F;
  endfunction

  function automatic logic [7:0] p8(input int b);
    return 8'(b * 53 + 29) ^ 8'hC3;
  endfunction

  function automatic logic [7:0] mbyte(input int b);
    return b[0] ? model[b >> 1][7:0] : model[b >> 1][15:8];
  endfunction

  task automatic put_byte(input int b, input logic [7:0] v);
    if (b[0]) model[b >> 1][7:0] = v;
    else      model[b >> 1][15:8] = v;
  endtask

  task automatic bit_out(input logic b);
    di = b;
    clk_n(2);
    sk = 1'b1;
    clk_n(4);
    sk = 1'b0;
    clk_n(2);
  endtask

  task automatic cs_on();
    cs = 1'b1;
    clk_n(3);
  endtask

  task automatic cs_off();
    cs = 1'b0;
    di = 1'b0;
    clk_n(4);
  endtask

  task automatic send_hdr(input logic [1:0] op, input int addr, input int aw);
    bit_out(1'b1);
    bit_out(op[1]);
    bit_out(op[0]);
    for (int i = aw - 1; i >= 0; i--) bit_out(addr[i]);
  endtask

  task automatic send_data(input logic [15:0] d, input int dw);
    for (int i = dw - 1; i >= 0; i--) bit_out(d[i]);
  endtask

  // lower chip select, then raise it and poll status until ready
  task automatic finish_prog();
    cs = 1'b0;
    di = 1'b0;
    clk_n(CSMIN + 3);
    cs = 1'b1;
    clk_n(4);
    st_cyc = CSMIN + 7;
    st_oe0 = do_oe;
    st_do0 = do_o;
    while (!(do_oe && do_o) && st_cyc < 2000) begin
      clk_n(1);
      st_cyc++;
    end
    cs_off();
  endtask

  task automatic wr(input logic x16, input int addr, input logic [15:0] d);
    org_x16 = x16;
    cs_on();
    send_hdr(2'b01, addr, x16 ? 6 : 7);
    send_data(d, x16 ? 16 : 8);
    if (en_model) begin
      finish_prog();
      if (x16) model[addr] = d;
      else     put_byte(addr, d[7:0]);
    end else begin
      cs_off();
    end
  endtask

  task automatic er(input logic x16, input int addr);
    org_x16 = x16;
    cs_on();
    send_hdr(2'b11, addr, x16 ? 6 : 7);
    if (en_model) begin
      finish_prog();
      if (x16) model[addr] = 16'hFFFF;
      else     put_byte(addr, 8'hFF);
    end else begin
      cs_off();
    end
  endtask

  // code: 11 enable, 00 disable, 10 erase all, 01 write all
  task automatic ext(input logic x16, input logic [1:0] code, input logic [15:0] d);
    int aw;
    aw = x16 ? 6 : 7;
    org_x16 = x16;
    cs_on();
    send_hdr(2'b00, int'(code) << (aw - 2), aw);
    if (code == 2'b01) send_data(d, x16 ? 16 : 8);
    if (code == 2'b11) begin
      en_model = 1'b1;
      cs_off();
    end else if (code == 2'b00) begin
      en_model = 1'b0;
      cs_off();
    end else if (!en_model) begin
      cs_off();
    end else begin
      finish_prog();
      for (int i = 0; i < 64; i++)
        model[i] = (code == 2'b10) ? 16'hFFFF : (x16 ? d : {d[7:0], d[7:0]});
    end
  endtask

  task automatic rd(input logic x16, input int addr, input int lead,
                    output logic [15:0] val, output logic dummy_ok);
    int dw;
    dw = x16 ? 16 : 8;
    org_x16 = x16;
    cs_on();
    for (int i = 0; i < lead; i++) bit_out(1'b0);
    send_hdr(2'b10, addr, x16 ? 6 : 7);
    dummy_ok = do_oe && !do_o;
    val = '0;
    for (int i = 0; i < dw; i++) begin
      bit_out(1'b0);
      val = {val[14:0], do_o};
    end
    cs_off();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic dok;
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    clk_n(5);
    rst_n = 1'b1;
    clk_n(3);

    // R1: reset state
    chk("R1 oe after reset", 16'(do_oe), 16'h0);
    rd(1'b1, 5, 0, v, dok);
    chk("R1 erased word", v, 16'hFFFF);
    chk("R2 dummy bit", 16'(dok), 16'h1);

    // R4: disabled after reset, write and write-all ignored
    wr(1'b1, 3, 16'h1234);
    ext(1'b1, 2'b01, 16'h0000);
    rd(1'b1, 3, 0, v, dok);
    chk("R4 write ignored when disabled", v, 16'hFFFF);
    rd(1'b1, 40, 0, v, dok);
    chk("R4 write-all ignored when disabled", v, 16'hFFFF);

    // R5: enable, R6 write, R8 status timing
    ext(1'b1, 2'b11, 16'h0);
    wr(1'b1, 3, 16'h1234);
    chk("R8 status oe during busy", 16'(st_oe0), 16'h1);
    chk("R8 status busy value", 16'(st_do0), 16'h0);
    chk("R8 busy length in window",
        16'((st_cyc >= PROG + 3 && st_cyc <= PROG + 5) ? 1 : 0), 16'h1);
    rd(1'b1, 3, 0, v, dok);
    chk("R6 write without erase", v, 16'h1234);
    chk("R2 dummy bit after write", 16'(dok), 16'h1);
    wr(1'b1, 3, 16'hA0C5);
    rd(1'b1, 3, 0, v, dok);
    chk("R6 overwrite", v, 16'hA0C5);

    // R9: too-short chip select low gives no status; long enough gives it
    org_x16 = 1'b1;
    cs_on();
    send_hdr(2'b01, 4, 6);
    send_data(16'h4C4C, 16);
    cs = 1'b0;
    clk_n(2);
    cs = 1'b1;
    clk_n(6);
    chk("R9 no status after short low", 16'(do_oe), 16'h0);
    cs = 1'b0;
    clk_n(2);
    chk("R9 oe low while cs low", 16'(do_oe), 16'h0);
    clk_n(CSMIN + 2);
    cs = 1'b1;
    clk_n(4);
    chk("R9 status after long low", 16'({do_oe, do_o}), 16'h2);
    while (!(do_oe && do_o)) clk_n(1);
    cs_off();
    model[4] = 16'h4C4C;
    rd(1'b1, 4, 0, v, dok);
    chk("R9 write committed", v, 16'h4C4C);

    // R11: a disable frame sent during busy is not decoded
    org_x16 = 1'b1;
    cs_on();
    send_hdr(2'b01, 7, 6);
    send_data(16'h7777, 16);
    cs = 1'b0;
    clk_n(CSMIN + 3);
    cs = 1'b1;
    clk_n(4);
    chk("R11 busy before frame", 16'({do_oe, do_o}), 16'h2);
    send_hdr(2'b00, 0, 6);
    chk("R11 still busy after frame", 16'({do_oe, do_o}), 16'h2);
    while (!(do_oe && do_o)) clk_n(1);
    cs_off();
    model[7] = 16'h7777;
    wr(1'b1, 8, 16'h8888);
    rd(1'b1, 8, 0, v, dok);
    chk("R11 enable survived busy frame", v, 16'h8888);

    // R3/R6: x16 sweep of all words
    for (int a = 0; a < 64; a++) wr(1'b1, a, p16(a));
    for (int a = 0; a < 64; a++) begin
      rd(1'b1, a, 0, v, dok);
      chk("R3 x16 word sweep", v, model[a]);
    end

    // R3: byte view of the same storage
    for (int b = 0; b < 128; b++) begin
      rd(1'b0, b, 0, v, dok);
      chk("R3 x8 byte mapping", v, {8'h00, mbyte(b)});
    end

    // R3/R6: x8 write sweep, read back as words
    for (int b = 0; b < 128; b++) wr(1'b0, b, {8'h00, p8(b)});
    for (int a = 0; a < 64; a++) begin
      rd(1'b1, a, 0, v, dok);
      chk("R3 x8 writes seen as words", v, model[a]);
    end

    // R6: byte erase leaves neighbour intact
    er(1'b0, 10);
    rd(1'b1, 5, 0, v, dok);
    chk("R6 byte erase", v, model[5]);
    er(1'b1, 9);
    rd(1'b1, 9, 0, v, dok);
    chk("R6 word erase", v, 16'hFFFF);

    // R10: leading zeros and aborted frame
    rd(1'b1, 12, 3, v, dok);
    chk("R10 leading zeros ignored", v, model[12]);
    org_x16 = 1'b1;
    cs_on();
    send_hdr(2'b01, 12, 6);
    send_data(16'h0003, 5);
    cs_off();
    clk_n(PROG + 10);
    rd(1'b1, 12, 0, v, dok);
    chk("R10 aborted write discarded", v, model[12]);

    // R7: write-all and erase-all in both organizations
    ext(1'b1, 2'b01, 16'hC35A);
    for (int a = 0; a < 64; a += 9) begin
      rd(1'b1, a, 0, v, dok);
      chk("R7 write-all x16", v, 16'hC35A);
    end
    ext(1'b1, 2'b10, 16'h0);
    for (int a = 1; a < 64; a += 13) begin
      rd(1'b1, a, 0, v, dok);
      chk("R7 erase-all", v, 16'hFFFF);
    end
    ext(1'b0, 2'b01, 16'h0096);
    for (int a = 2; a < 64; a += 15) begin
      rd(1'b1, a, 0, v, dok);
      chk("R7 write-all x8", v, 16'h9696);
    end

    // R5: disable blocks later writes and erases
    ext(1'b0, 2'b00, 16'h0);
    wr(1'b1, 20, 16'h0F0F);
    er(1'b0, 41);
    rd(1'b1, 20, 0, v, dok);
    chk("R5 disable blocks write", v, 16'h9696);
    rd(1'b0, 41, 0, v, dok);
    chk("R5 disable blocks erase", v, 16'h0096);
    chk("R1 oe idle at end", 16'(do_oe), 16'h0);

    summary();
    $finish;
  end

endmodule